// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decode

This block takes one 32-bit instruction word together with the two source register values and the current PC, works out which integer operation the word encodes, and produces the value to be written back to the destination register. It covers addition and subtraction, signed and unsigned less-than compares, the four logical operations, shifts by a register or by a constant, the low and high halves of 32x32 multiplies, signed and unsigned divide and remainder, and the two upper-immediate forms. One of these forms loads a constant and the other adds it to the PC.

An instruction is accepted by pulsing `issue` while `busy` is low. Every operation except divide and remainder finishes one cycle later. Divide and remainder run on an iterative shift-subtract engine: `busy` stays high for the whole run and `done` comes exactly XLEN+1 cycles after the issue edge. On the `done` cycle, `result`, `wr_idx`, `wr_en` and `illegal` describe the finished instruction. The register file, memory access and branching lie outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: The destination index is taken from bits 4:0 of the instruction and is reported on `wr_idx` during the `done` cycle. Source values come from the `rj_val` and `rk_val` ports.
- R2: When bits 31:15 equal 0x00020, 0x00022, 0x00028, 0x00029, 0x0002A or 0x0002B, the result is add, subtract (rj-rk), NOR, AND, OR or XOR respectively. `done` rises one cycle after issue.
- R3: Bits 31:15 = 0x00024 gives a signed compare (rj<rk yields 1, otherwise 0). 0x00025 gives the same compare done unsigned.
- R4: Register shifts use bits 31:15 = 0x0002E (left), 0x0002F (logical right) and 0x00030 (arithmetic right), and only the low 5 bits of rk set the amount. Constant shifts use 0x00081, 0x00089 and 0x00091, with the amount in bits 14:10.
- R5: Bits 31:22 select 0x008 signed less-than-immediate, 0x009 unsigned less-than against the sign-extended immediate, 0x00A add-immediate, 0x00D/0x00E/0x00F AND/OR/XOR immediate. The immediate is in bits 21:10. It is sign-extended for the first three and zero-extended for the logical three.
- R6: Bits 31:15 = 0x00038 returns the low 32 bits of the product. 0x00039 returns the high 32 bits of the signed 64-bit product, and 0x0003A returns the high 32 bits of the unsigned product.
- R7: Bits 31:25 = 0001010 writes bits 24:5 shifted left by 12. Bits 31:25 = 0001110 writes that value plus `pc`.
- R8: Bits 31:15 = 0x00040/0x00041/0x00042/0x00043 give signed quotient, signed remainder, unsigned quotient and unsigned remainder. The quotient truncates toward zero and a signed remainder takes the sign of the dividend. `busy` is high from the cycle after issue, and `done` appears XLEN+1 cycles after the issue edge.
- R9: A zero divisor raises no error. The quotient is all ones and the remainder equals the dividend, for both signed and unsigned forms.
- R10: A signed divide of the most negative value by -1 gives the most negative value, with remainder 0.
- R11: When the destination index is 0, `wr_en` stays low while `done` is still reported.
- R12: A word matching none of the encodings above completes with `illegal` high, `wr_en` low and `result` zero.
- R13: An `issue` pulse while `busy` is high is dropped. Only the running divide completes, and no further `done` follows.
- R14: During and after reset, `busy`, `done` and `wr_en` are low until an instruction is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Start the instruction on `insn` (taken only when not busy) |
| insn | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction, for the PC-relative form |
| rj_val | input | 32 | First source register value |
| rk_val | input | 32 | Second source register value |
| busy | output | 1 | Divide in progress; issue is ignored |
| done | output | 1 | One-cycle completion strobe |
| wr_en | output | 1 | Result is to be written to `wr_idx` |
| wr_idx | output | 5 | Destination register index |
| result | output | 32 | Computed value |
| illegal | output | 1 | Completed instruction was not recognised |

## Verification
The hardest case to reach from the ports is an instruction arriving in the middle of a divide. The bench starts a divide, confirms `busy`, then issues an add aimed at a different register several cycles later. It then counts every `done` strobe over a window well past the divide latency, and requires exactly one strobe, carrying the divide's result and destination. The divide corner cases (zero divisor with either sign, and the signed overflow case) are issued as directed tests, each with its own expected quotient or remainder.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  localparam int XLEN = 32;
  localparam int SHW  = $clog2(XLEN);

  typedef enum logic [4:0] {
    OP_ADD, OP_SUB, OP_SLT, OP_SLTU, OP_NOR, OP_AND, OP_OR, OP_XOR,
    OP_SLL, OP_SRL, OP_SRA, OP_MUL, OP_MULH, OP_MULHU,
    OP_DIV, OP_MOD, OP_DIVU, OP_MODU, OP_LUI, OP_PCREL, OP_BAD
  } op_e;

  // single-cycle arithmetic; b is already the selected second operand
  function automatic logic [XLEN-1:0] alu_fn(op_e op, logic [XLEN-1:0] a,
                                             logic [XLEN-1:0] b,
                                             logic [XLEN-1:0] pc);
    logic signed [2*XLEN-1:0] ps;
    logic [2*XLEN-1:0] pu;
    logic [SHW-1:0] sh;
    sh = b[SHW-1:0];
    ps = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});
    pu = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    case (op)
      OP_ADD:   return a + b;
      OP_SUB:   return a - b;
      OP_SLT:   return {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      OP_SLTU:  return {{(XLEN-1){1'b0}}, a < b};
      OP_NOR:   return ~(a | b);
      OP_AND:   return a & b;
      OP_OR:    return a | b;
      OP_XOR:   return a ^ b;
      OP_SLL:   return a << sh;
      OP_SRL:   return a >> sh;
      OP_SRA:   return $signed(a) >>> sh;
      OP_MUL:   return pu[XLEN-1:0];
      OP_MULH:  return ps[2*XLEN-1:XLEN];
      OP_MULHU: return pu[2*XLEN-1:XLEN];
      OP_LUI:   return b;
      OP_PCREL: return pc + b;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
  import int_exec_pkg::*;
(
  input  logic [XLEN-1:0] insn,
  output op_e             op,
  output logic            use_imm,
  output logic [XLEN-1:0] imm,
  output logic            is_div,
  output logic            bad
);
  logic [16:0] f17;
  logic [9:0]  f10;
  logic [6:0]  f7;
  logic [XLEN-1:0] simm, zimm, uimm, shimm;

  assign f17   = insn[31:15];
  assign f10   = insn[31:22];
  assign f7    = insn[31:25];
  assign simm  = {{(XLEN-12){insn[21]}}, insn[21:10]};
  assign zimm  = {{(XLEN-12){1'b0}}, insn[21:10]};
  assign uimm  = {insn[24:5], 12'h000};
  assign shimm = {{(XLEN-5){1'b0}}, insn[14:10]};

  always_comb begin
    op = OP_BAD;
    use_imm = 1'b0;
    imm = '0;
    case (f17)
      17'h00020: op = OP_ADD;
      17'h00022: op = OP_SUB;
      17'h00024: op = OP_SLT;
      17'h00025: op = OP_SLTU;
      17'h00028: op = OP_NOR;
      17'h00029: op = OP_AND;
      17'h0002A: op = OP_OR;
      17'h0002B: op = OP_XOR;
      17'h0002E: op = OP_SLL;
      17'h0002F: op = OP_SRL;
      17'h00030: op = OP_SRA;
      17'h00038: op = OP_MUL;
      17'h00039: op = OP_MULH;
      17'h0003A: op = OP_MULHU;
      17'h00040: op = OP_DIV;
      17'h00041: op = OP_MOD;
      17'h00042: op = OP_DIVU;
      17'h00043: op = OP_MODU;
      17'h00081: begin op = OP_SLL; use_imm = 1'b1; imm = shimm; end
      17'h00089: begin op = OP_SRL; use_imm = 1'b1; imm = shimm; end
      17'h00091: begin op = OP_SRA; use_imm = 1'b1; imm = shimm; end
      default: begin
        use_imm = 1'b1;
        case (f10)
          10'h008: begin op = OP_SLT;  imm = simm; end
          10'h009: begin op = OP_SLTU; imm = simm; end
          10'h00A: begin op = OP_ADD;  imm = simm; end
          10'h00D: begin op = OP_AND;  imm = zimm; end
          10'h00E: begin op = OP_OR;   imm = zimm; end
          10'h00F: begin op = OP_XOR;  imm = zimm; end
          default: begin
            imm = uimm;
            if (f7 == 7'b0001010)      op = OP_LUI;
            else if (f7 == 7'b0001110) op = OP_PCREL;
            else                       use_imm = 1'b0;
          end
        endcase
      end
    endcase
  end

  assign is_div = (op == OP_DIV) || (op == OP_MOD) || (op == OP_DIVU) || (op == OP_MODU);
  assign bad    = (op == OP_BAD);
endmodule

// File: rtl/int_div_iter.sv
module int_div_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic         rem_sel,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] value
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0] acc, quo, dsr, dvd_raw;
  logic [CW-1:0] cnt;
  logic neg_q, neg_r, by_zero, sel_r, busy_q, done_q;
  logic [W:0] shifted, trial;
  logic fits;
  logic [W-1:0] q_fin, r_fin;

  assign shifted = {acc, quo[W-1]};
  assign trial   = shifted - {1'b0, dsr};
  assign fits    = ~trial[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; quo <= '0; dsr <= '0; dvd_raw <= '0; cnt <= '0;
      neg_q <= 1'b0; neg_r <= 1'b0; by_zero <= 1'b0; sel_r <= 1'b0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        acc     <= '0;
        quo     <= (sgn && dvd[W-1]) ? -dvd : dvd;
        dsr     <= (sgn && dvs[W-1]) ? -dvs : dvs;
        dvd_raw <= dvd;
        neg_q   <= sgn && (dvd[W-1] ^ dvs[W-1]);
        neg_r   <= sgn && dvd[W-1];
        by_zero <= (dvs == '0);
        sel_r   <= rem_sel;
        cnt     <= '0;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        acc <= fits ? trial[W-1:0] : shifted[W-1:0];
        quo <= {quo[W-2:0], fits};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign q_fin = neg_q ? -quo : quo;
  assign r_fin = neg_r ? -acc : acc;
  assign value = by_zero ? (sel_r ? dvd_raw : '1) : (sel_r ? r_fin : q_fin);
  assign busy  = busy_q;
  assign done  = done_q;
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [31:0] insn,
  input  logic [31:0] pc,
  input  logic [31:0] rj_val,
  input  logic [31:0] rk_val,
  output logic        busy,
  output logic        done,
  output logic        wr_en,
  output logic [4:0]  wr_idx,
  output logic [31:0] result,
  output logic        illegal
);
  op_e dec_op;
  logic dec_use_imm, dec_is_div, dec_bad;
  logic [XLEN-1:0] dec_imm, opnd_b;
  logic accept, div_start, div_busy, div_done;
  logic [XLEN-1:0] div_val, alu_q;
  logic alu_done, bad_q;
  logic [4:0] rd_q;

  int_exec_decode u_dec (
    .insn(insn), .op(dec_op), .use_imm(dec_use_imm), .imm(dec_imm),
    .is_div(dec_is_div), .bad(dec_bad)
  );

  assign opnd_b    = dec_use_imm ? dec_imm : rk_val;
  assign accept    = issue && !div_busy;
  assign div_start = accept && dec_is_div;

  int_div_iter #(.W(XLEN)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .sgn((dec_op == OP_DIV) || (dec_op == OP_MOD)),
    .rem_sel((dec_op == OP_MOD) || (dec_op == OP_MODU)),
    .dvd(rj_val), .dvs(rk_val),
    .busy(div_busy), .done(div_done), .value(div_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alu_done <= 1'b0;
      alu_q    <= '0;
      rd_q     <= '0;
      bad_q    <= 1'b0;
    end else begin
      alu_done <= accept && !dec_is_div;
      if (accept) begin
        rd_q  <= insn[4:0];
        bad_q <= dec_bad;
        alu_q <= dec_bad ? '0 : alu_fn(dec_op, rj_val, opnd_b, pc);
      end
    end
  end

  assign busy    = div_busy;
  assign done    = alu_done || div_done;
  assign result  = div_done ? div_val : alu_q;
  assign wr_idx  = rd_q;
  assign illegal = done && bad_q;
  assign wr_en   = done && !bad_q && (rd_q != 5'd0);
endmodule

// File: rtl/int_exec_chk.sv
module int_exec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issue,
  input logic       busy,
  input logic       done,
  input logic       wr_en,
  input logic       illegal,
  input logic [4:0] wr_idx,
  input logic       dec_is_div
);
  // R12
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> !wr_en);
  // R11
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx == 5'd0) |-> !wr_en);
  // R8
  div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !busy && dec_is_div) |=> busy);
  // R8
  div_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R13
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  // R1
  write_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);
endmodule

bind int_exec_unit int_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .busy(busy), .done(done),
  .wr_en(wr_en), .illegal(illegal), .wr_idx(wr_idx), .dec_is_div(dec_is_div)
);

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_LAT = 33;

  logic clk = 1'b0, rst_n = 1'b0, issue = 1'b0;
  logic [31:0] insn = '0, pc = 32'h0000_1000, rj_val = '0, rk_val = '0;
  logic busy, done, wr_en, illegal;
  logic [4:0] wr_idx;
  logic [31:0] result;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn), .pc(pc),
    .rj_val(rj_val), .rk_val(rk_val), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_idx(wr_idx), .result(result), .illegal(illegal)
  );

  // {req, insn, rj, rk, expected}; rd = 3 in every row
  localparam int NV = 29;
  localparam logic [135:0] VEC [NV] = '{
    {8'd2,  17'h00020, 15'd3, 32'd7,          32'd5,          32'd12},         // R2 add
    {8'd2,  17'h00022, 15'd3, 32'd5,          32'd7,          32'hFFFFFFFE},   // R2 sub
    {8'd3,  17'h00024, 15'd3, 32'hFFFFFFFF,   32'd1,          32'd1},          // R3 slt
    {8'd3,  17'h00025, 15'd3, 32'hFFFFFFFF,   32'd1,          32'd0},          // R3 sltu
    {8'd2,  17'h00028, 15'd3, 32'hF0F0F0F0,   32'h0F0F0000,   32'h00000F0F},   // R2 nor
    {8'd2,  17'h00029, 15'd3, 32'hFF00FF00,   32'h0FF00FF0,   32'h0F000F00},   // R2 and
    {8'd2,  17'h0002A, 15'd3, 32'hFF00FF00,   32'h0FF00FF0,   32'hFFF0FFF0},   // R2 or
    {8'd2,  17'h0002B, 15'd3, 32'hFF00FF00,   32'h0FF00FF0,   32'hF0F0F0F0},   // R2 xor
    {8'd4,  17'h0002E, 15'd3, 32'd1,          32'h23,         32'd8},          // R4 sll low5
    {8'd4,  17'h0002F, 15'd3, 32'h80000000,   32'd31,         32'd1},          // R4 srl
    {8'd4,  17'h00030, 15'd3, 32'h80000000,   32'd4,          32'hF8000000},   // R4 sra
    {8'd6,  17'h00038, 15'd3, 32'h00010001,   32'h00010001,   32'h00020001},   // R6 mul
    {8'd6,  17'h00039, 15'd3, 32'hFFFFFFFF,   32'd2,          32'hFFFFFFFF},   // R6 mulh
    {8'd6,  17'h0003A, 15'd3, 32'hFFFFFFFF,   32'd2,          32'd1},          // R6 mulhu
    {8'd4,  17'h00081, 5'd4, 10'd3, 32'd3,    32'hDEAD,       32'h30},         // R4 slli
    {8'd4,  17'h00089, 5'd8, 10'd3, 32'h12345678, 32'd0,      32'h00123456},   // R4 srli
    {8'd4,  17'h00091, 5'd8, 10'd3, 32'h87654321, 32'd0,      32'hFF876543},   // R4 srai
    {8'd5,  10'h008, 12'hFFF, 10'd3, 32'hFFFFFFFE, 32'd0,     32'd1},          // R5 slti
    {8'd5,  10'h009, 12'hFFF, 10'd3, 32'hFFFFFFFE, 32'd0,     32'd1},          // R5 sltui
    {8'd5,  10'h00A, 12'h800, 10'd3, 32'h1000,     32'd0,     32'h800},        // R5 addi
    {8'd5,  10'h00D, 12'hFFF, 10'd3, 32'hFFFFFFFF, 32'd0,     32'hFFF},        // R5 andi
    {8'd5,  10'h00E, 12'h800, 10'd3, 32'd0,        32'd0,     32'h800},        // R5 ori
    {8'd5,  10'h00F, 12'hFFF, 10'd3, 32'hFFFF0000, 32'd0,     32'hFFFF0FFF},   // R5 xori
    {8'd7,  7'b0001010, 20'hABCDE, 5'd3, 32'd0,    32'd0,     32'hABCDE000},   // R7 lu12i
    {8'd7,  7'b0001110, 20'h00001, 5'd3, 32'd0,    32'd0,     32'h00002000},   // R7 pc-rel
    {8'd8,  17'h00040, 15'd3, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD},   // R8 div
    {8'd8,  17'h00041, 15'd3, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFF},   // R8 mod
    {8'd8,  17'h00042, 15'd3, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC},   // R8 divu
    {8'd8,  17'h00043, 15'd3, 32'hFFFFFFF9,   32'd2,          32'd1}           // R8 modu
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] res, output logic we, output logic ill,
                        output logic [4:0] idx, output int lat);
    @(negedge clk);
    insn = ins; rj_val = a; rk_val = b; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = result; we = wr_en; ill = illegal; idx = wr_idx;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog got=%0d exp=%0d", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] res;
    logic we, ill;
    logic [4:0] idx;
    int lat;
    int npulse;
    repeat (3) @(negedge clk);
    // R14 reset state
    chk("R14 busy", {31'd0, busy}, 32'd0);
    chk("R14 done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 wr_en", {31'd0, wr_en}, 32'd0);
    chk("R14 done after", {31'd0, done}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [135:0] v;
      v = VEC[i];
      run_op(v[127:96], v[95:64], v[63:32], res, we, ill, idx, lat);
      checks++;
      if (res !== v[31:0] || we !== 1'b1 || ill !== 1'b0 ||
          lat != ((v[135:128] == 8'd8) ? DIV_LAT : 1)) begin
        fails++;
        $display("FAIL R%0d vec%0d got=%h/we%0d/lat%0d exp=%h/we1/lat%0d", v[135:128], i,
                 res, we, lat, v[31:0], (v[135:128] == 8'd8) ? DIV_LAT : 1);
      end
    end

    // R1 destination index from bits 4:0
    run_op({17'h00020, 5'd9, 5'd8, 5'd17}, 32'd1, 32'd2, res, we, ill, idx, lat);
    chk("R1 wr_idx", {27'd0, idx}, 32'd17);
    chk("R1 result", res, 32'd3);

    // R9 zero divisor
    run_op({17'h00040, 15'd4}, 32'd5, 32'd0, res, we, ill, idx, lat);
    chk("R9 div by zero", res, 32'hFFFFFFFF);
    run_op({17'h00041, 15'd4}, 32'hFFFFFFF9, 32'd0, res, we, ill, idx, lat);
    chk("R9 mod by zero", res, 32'hFFFFFFF9);
    run_op({17'h00042, 15'd4}, 32'd9, 32'd0, res, we, ill, idx, lat);
    chk("R9 divu by zero", res, 32'hFFFFFFFF);
    run_op({17'h00043, 15'd4}, 32'hFFFFFFF9, 32'd0, res, we, ill, idx, lat);
    chk("R9 modu by zero", res, 32'hFFFFFFF9);

    // R10 signed overflow
    run_op({17'h00040, 15'd4}, 32'h80000000, 32'hFFFFFFFF, res, we, ill, idx, lat);
    chk("R10 div min/-1", res, 32'h80000000);
    run_op({17'h00041, 15'd4}, 32'h80000000, 32'hFFFFFFFF, res, we, ill, idx, lat);
    chk("R10 mod min/-1", res, 32'd0);

    // R11 write to register 0 suppressed
    run_op({17'h00020, 15'd0}, 32'd1, 32'd1, res, we, ill, idx, lat);
    chk("R11 wr_en", {31'd0, we}, 32'd0);
    chk("R11 done latency", lat, 32'd1);

    // R12 unmatched encodings
    run_op(32'hFFFFFFFF, 32'd1, 32'd1, res, we, ill, idx, lat);
    chk("R12 illegal", {31'd0, ill}, 32'd1);
    chk("R12 wr_en", {31'd0, we}, 32'd0);
    chk("R12 result", res, 32'd0);
    run_op({17'h00021, 15'd3}, 32'd1, 32'd1, res, we, ill, idx, lat);
    chk("R12 illegal gap code", {30'd0, ill, we}, 32'd2);

    // R13 issue while busy is dropped
    @(negedge clk);
    insn = {17'h00040, 15'd5}; rj_val = 32'd100; rk_val = 32'd7; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    chk("R8 busy after issue", {31'd0, busy}, 32'd1);
    npulse = 0;
    res = '0; idx = '0;
    for (int c = 1; c <= 45; c++) begin
      if (c == 4) begin
        insn = {17'h00020, 15'd6}; rj_val = 32'd1; rk_val = 32'd1; issue = 1'b1;
      end else begin
        issue = 1'b0;
      end
      if (done) begin
        npulse++;
        res = result; idx = wr_idx;
      end
      @(negedge clk);
    end
    chk("R13 done count", npulse, 32'd1);
    chk("R13 result", res, 32'd14);
    chk("R13 wr_idx", {27'd0, idx}, 32'd5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule